// File: doc/BRIEF.md
# Interrupt Controller with Fast-Interrupt Routing

This block collects one-cycle event pulses from thirteen peripheral and timebase sources into sticky pending bits. It masks them with a software-written enable register and drives a single interrupt request line together with the 16-bit vector address the processor should jump to. Several sources share each vector. When more than one vector has work, a fixed priority picks the lowest vector address.

A 3-bit select register sends one source class to a separate fast-interrupt output. The class can be a graphics unit, a sound unit, either timer, the serial port, the external pins or the converter. The chosen class is withheld from the ordinary request line. Software reads the pending bits at the status address and clears them by writing ones to that same address. The register port is a plain single-cycle write strobe with a combinational read. The interface has no data stream, so there is no back-pressure.

Top module: `irq_router`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0, the fast-select register reads 7 (off), and `irq`, `fiq` and `irq_vec` are all 0.
- R2: A pulse on `src_pulse[b]` for an implemented bit b sets status bit b from the next cycle on. The implemented bits are 13 (converter), 12 (external 2), 11 (timer A), 10 (timer B), 9 (external 1), 8 (serial), 7 (key change), 6 (4096 Hz), 5 (2048 Hz), 4 (1024 Hz), 3 (4 Hz), 1 (timebase 1) and 0 (timebase 2). Pulses on bits 2, 14 and 15 are ignored, and those bits always read 0.
- R3: A pending bit stays set until a write to address 1 carries a 1 in that bit. Writing 0 leaves the bit unchanged. A pulse in the same cycle as a clear of the same bit leaves the bit set.
- R4: Address 0 is the enable register. It is readable and writable, and its unimplemented bits read 0. `irq` is 1 exactly when some bit is both pending and enabled and that bit is outside the fast-routed class.
- R5: `irq_vec` gives the vector for the requesting group, as follows:
  - bits 11 and 10: 0xFFFA
  - bits 13 and 8: 0xFFFB
  - bits 12 and 9: 0xFFFD
  - bits 6, 5 and 4: 0xFFFE
  - bits 7, 3, 1 and 0: 0xFFFF

  `irq_vec` is 0 when `irq` is 0.
- R6: When several groups request at once, `irq_vec` is the lowest of their vector addresses.
- R7: Address 2 holds the 3-bit fast-select code in its low bits. The codes are:
  - 0: graphics, taken from `ppu_irq`
  - 1: sound, taken from `spu_irq`
  - 2: timer A, bit 11
  - 3: timer B, bit 10
  - 4: serial, bit 8
  - 5: external, bits 9 and 12
  - 6: converter, bit 13
  - 7: none

  `fiq` is 1 when the selected class is active. A bitmap class is active when it is both pending and enabled. Code 7 keeps `fiq` at 0.
- R8: Bits of the selected class never raise `irq` or choose `irq_vec`, however they are enabled.
- R9: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 16 | One-cycle event pulses, one per status bit |
| ppu_irq | input | 1 | Graphics unit request level (fast class 0) |
| spu_irq | input | 1 | Sound unit request level (fast class 1) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 enable, 1 status/clear, 2 fast select, 3 none |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Ordinary interrupt request |
| irq_vec | output | 16 | Vector address of the winning group, 0 when idle |
| fiq | output | 1 | Fast interrupt request |

## Verification
A corrupted pending latch shows on the status read and on `irq` in the first cycle after the pulse or clear that should have changed it. A wrong group decode or a wrong priority shows as a wrong `irq_vec` in that same cycle. The bench therefore sweeps every combination of the thirteen implemented bits and compares status, request and vector one cycle after each pulse. It then crosses every fast-select code with every single bit and with both level inputs, so that a wrong routing or exclusion shows as a mismatch between `fiq` and `irq` at once.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int DW      = 16;
  localparam int NVEC    = 6;
  localparam logic [DW-1:0] IMPL_MASK = 16'h3FFB;
  localparam logic [DW-1:0] VEC_BASE  = 16'hFFFA;

  typedef enum logic [2:0] {
    FQ_PPU  = 3'd0,
    FQ_SPU  = 3'd1,
    FQ_TMRA = 3'd2,
    FQ_TMRB = 3'd3,
    FQ_SER  = 3'd4,
    FQ_EXT  = 3'd5,
    FQ_ADC  = 3'd6,
    FQ_OFF  = 3'd7
  } fiq_code_e;

  // Sources that share vector VEC_BASE + k.
  function automatic logic [DW-1:0] vec_group(input int k);
    case (k)
      0:       vec_group = 16'h0C00;
      1:       vec_group = 16'h2100;
      2:       vec_group = 16'h0000;
      3:       vec_group = 16'h1200;
      4:       vec_group = 16'h0070;
      default: vec_group = 16'h008B;
    endcase
  endfunction

  // Status bits that belong to a fast-select class.
  function automatic logic [DW-1:0] class_mask(input fiq_code_e c);
    case (c)
      FQ_TMRA: class_mask = 16'h0800;
      FQ_TMRB: class_mask = 16'h0400;
      FQ_SER:  class_mask = 16'h0100;
      FQ_EXT:  class_mask = 16'h1200;
      FQ_ADC:  class_mask = 16'h2000;
      default: class_mask = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= IMPL[i] & (set_i[i] | (pend_q[i] & ~clr_i[i]));
    end

    if (IMPL[i]) begin : g_chk
      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> pend_q[i]);
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    end else begin : g_chk_off
      p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[i]);
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_fiq_route.sv
module irq_fiq_route
  import irq_router_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  fiq_code_e     code_i,
  input  logic [DW-1:0] act_i,
  input  logic          ppu_i,
  input  logic          spu_i,
  output logic [DW-1:0] cmask_o,
  output logic          fiq_o
);

  logic bitmap_hit;

  assign cmask_o    = class_mask(code_i);
  assign bitmap_hit = |(act_i & cmask_o);

  always_comb begin
    case (code_i)
      FQ_PPU:  fiq_o = ppu_i;
      FQ_SPU:  fiq_o = spu_i;
      FQ_OFF:  fiq_o = 1'b0;
      default: fiq_o = bitmap_hit;
    endcase
  end

  p_fiq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == FQ_OFF) |-> !fiq_o);

endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick
  import irq_router_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] req_i,
  output logic          irq_o,
  output logic [DW-1:0] vec_o
);

  logic [NVEC-1:0] hit;
  logic [2:0]      win;

  for (genvar k = 0; k < NVEC; k++) begin : g_grp
    assign hit[k] = |(req_i & vec_group(k));
  end

  always_comb begin
    win = 3'd0;
    for (int k = NVEC - 1; k >= 0; k--) begin
      if (hit[k]) win = 3'(k);
    end
  end

  assign irq_o = |hit;
  assign vec_o = irq_o ? (VEC_BASE + DW'(win)) : '0;

  p_vec_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o >= VEC_BASE && vec_o != 16'hFFFC));
  p_vec_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   src_pulse,
  input  logic          ppu_irq,
  input  logic          spu_irq,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          irq,
  output logic [15:0]   irq_vec,
  output logic          fiq
);

  localparam logic [1:0] A_EN   = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_FSEL = 2'd2;

  logic [DW-1:0] en_q;
  fiq_code_e     fsel_q;
  logic [DW-1:0] pend;
  logic [DW-1:0] clr;
  logic [DW-1:0] act;
  logic [DW-1:0] cmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      fsel_q <= FQ_OFF;
    end else if (bus_wr) begin
      if (bus_addr == A_EN)   en_q   <= bus_wdata & IMPL_MASK;
      if (bus_addr == A_FSEL) fsel_q <= fiq_code_e'(bus_wdata[2:0]);
    end
  end

  assign clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  irq_pend_bank #(.W(DW), .IMPL(IMPL_MASK)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_pulse),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign act = pend & en_q;

  irq_fiq_route u_fiq (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (fsel_q),
    .act_i   (act),
    .ppu_i   (ppu_irq),
    .spu_i   (spu_irq),
    .cmask_o (cmask),
    .fiq_o   (fiq)
  );

  irq_vec_pick u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (act & ~cmask),
    .irq_o (irq),
    .vec_o (irq_vec)
  );

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_STAT:  bus_rdata = pend;
      A_FSEL:  bus_rdata = {13'd0, fsel_q};
      default: bus_rdata = '0;
    endcase
  end

  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(pend & en_q));
  p_fiq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(pend & en_q & ~cmask));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam int PERIOD = 10;
  localparam logic [15:0] IMPL = 16'h3FFB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_pulse = '0;
  logic        ppu_irq = 1'b0, spu_irq = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, irq_vec;
  logic        irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ppu_irq(ppu_irq),
    .spu_irq(spu_irq), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .irq_vec(irq_vec), .fiq(fiq)
  );

  function automatic logic [15:0] exp_vec(input logic [15:0] a);
    if      (a & 16'h0C00) return 16'hFFFA;
    else if (a & 16'h2100) return 16'hFFFB;
    else if (a & 16'h1200) return 16'hFFFD;
    else if (a & 16'h0070) return 16'hFFFE;
    else if (a & 16'h008B) return 16'hFFFF;
    else                   return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_cls(input int c);
    case (c)
      2: return 16'h0800;
      3: return 16'h0400;
      4: return 16'h0100;
      5: return 16'h1200;
      6: return 16'h2000;
      default: return 16'h0000;
    endcase
  endfunction

  // Spread a 13-bit index over the implemented bit positions.
  function automatic logic [15:0] expand(input int j);
    logic [15:0] m = '0;
    int n = 0;
    for (int b = 0; b < 16; b++) begin
      if (IMPL[b]) begin
        m[b] = j[n];
        n++;
      end
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] m);
    src_pulse = m;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 enable", d, 16'h0);
    rd(2'd1, d); chk("R1 status", d, 16'h0);
    rd(2'd2, d); chk("R1 fsel", d, 16'h7);
    chk("R1 irq", irq, 0); chk("R1 fiq", fiq, 0); chk("R1 vec", irq_vec, 0);

    // R2 unimplemented bits ignored
    pulse(16'hC004);
    rd(2'd1, d); chk("R2 unused status", d, 16'h0);

    // R4 enable readback masks unimplemented bits
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R4 enable readback", d, IMPL);
    chk("R2 unused no irq", irq, 0);

    // R3 write zero has no effect, set wins over clear
    pulse(16'h0800);
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk("R3 write0 keeps", d, 16'h0800);
    src_pulse = 16'h0800; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0800;
    @(negedge clk);
    src_pulse = '0; bus_wr = 1'b0;
    rd(2'd1, d); chk("R3 set beats clear", d, 16'h0800);
    wr(2'd1, 16'h0800);
    rd(2'd1, d); chk("R3 cleared", d, 16'h0);

    // R9 address 3
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); chk("R9 addr3 reads 0", d, 16'h0);
    rd(2'd0, d); chk("R9 enable intact", d, IMPL);
    rd(2'd2, d); chk("R9 fsel intact", d, 16'h7);

    // R4 partial enable masks irq
    wr(2'd0, 16'h0070);
    pulse(16'h0C00);
    chk("R4 masked irq", irq, 0);
    pulse(16'h0008);
    chk("R4 masked irq2", irq, 0);
    rd(2'd1, d); chk("R4 pending despite mask", d, 16'h0C08);
    // R6 priority with enable subset
    wr(2'd0, 16'h0008);
    chk("R6 vec subset", irq_vec, 16'hFFFF);
    wr(2'd0, 16'h0C08);
    chk("R6 vec low wins", irq_vec, 16'hFFFA);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'hFFFF);

    // R2 R5 R6 exhaustive sweep over implemented bits
    for (int j = 0; j < 8192; j++) begin
      logic [15:0] m;
      m = expand(j);
      pulse(m);
      rd(2'd1, d); chk("R2 status sweep", d, m);
      chk("R4 irq sweep", irq, (m != 0));
      chk("R5 R6 vec sweep", irq_vec, exp_vec(m));
      wr(2'd1, 16'hFFFF);
    end

    // R7 R8 fast routing sweep
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 16'(c));
      rd(2'd2, d); chk("R7 fsel readback", d, 16'(c));
      for (int b = 0; b < 16; b++) begin
        logic [15:0] m;
        m = IMPL & (16'h1 << b);
        pulse(16'h1 << b);
        chk("R7 fiq sweep", fiq, |(m & exp_cls(c)));
        chk("R8 irq excl sweep", irq, |(m & ~exp_cls(c)));
        chk("R8 vec excl sweep", irq_vec, exp_vec(m & ~exp_cls(c)));
        wr(2'd1, 16'hFFFF);
      end
      ppu_irq = 1'b1; #1;
      chk("R7 ppu route", fiq, (c == 0));
      chk("R8 ppu no irq", irq, 0);
      ppu_irq = 1'b0; spu_irq = 1'b1; #1;
      chk("R7 spu route", fiq, (c == 1));
      spu_irq = 1'b0;
      @(negedge clk);
    end

    // R7 enable gates a fast bitmap class
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0000);
    pulse(16'h0800);
    chk("R7 fiq needs enable", fiq, 0);
    wr(2'd0, 16'h0800);
    chk("R7 fiq enabled", fiq, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule